// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

An eight-line general-purpose I/O port reached through a simple byte-wide register bus. Each line has a direction bit that enables its pad driver. Pin values are read and written through an address window. The access address itself carries a per-line mask, so software can change one pin, or any chosen group of pins, in a single write and never needs a read-modify-write sequence.

A write in the data window updates only the lines that are both selected by the address mask and already set as outputs. Selected bits written to input lines are dropped. A read returns the masked line values and zero for every line not selected. Output lines read back their driven value. Input lines read the pad level after a two-flop synchronizer. The bus is one-cycle and has no handshake. Write effects take hold at the clock edge on which `bus_valid` and `bus_write` are high. Read data is combinational from the registered state while a read is presented.

Top module: `maskgpio_port`

## Requirements
- R1: After reset, the direction and output-data registers are all zero: `pad_oe` and `pad_out` are 0 and the direction register reads 0.
- R2: The direction register is at byte offset 0x400, is readable and writable, and bit n set to 1 makes line n an output, with `pad_oe[n]` equal to direction bit n.
- R3: A write at an offset in 0x000..0x3FF uses address bit (n+2) as the mask for line n; only lines whose mask bit is 1 take `bus_wdata[n]`, and all other lines keep their output value.
- R4: A data write to a line that is an input when the write happens is discarded: switching the line to output afterwards shows the old output value, and only a second data write presets it.
- R5: A read at an offset in 0x000..0x3FF returns 0 in every bit whose address mask bit (n+2) is 0.
- R6: In a masked read, bit n returns the driven output value if line n is an output, and the synchronized pad value if it is an input.
- R7: A pad input change becomes visible to reads after exactly two rising clock edges, and not after one.
- R8: Reads of any offset other than the data window and 0x400 return 0, and writes to such offsets change no state.
- R9: `pad_out[n]` always equals the output-data bit n.
- R10: With `bus_valid` low, no register changes, whatever the other bus inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is presented |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The hardest case to reach is a line that was written while it was an input and is then turned into an output. Only the order of the writes shows that the earlier data was dropped, so the stimulus first sets a mixed direction pattern, writes all eight bits, switches every line to output and checks that the formerly input lines drive their old zero. The synchronizer depth is also hard to see from the ports. The bench changes the pad at a falling edge and reads once between the first and second rising edges, then once after the second.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_DATA = 2'd1,
      RGN_DIR  = 2'd2
   } region_e;

   // Classify an offset: the data window lies below the direction offset
   function automatic region_e classify(input int unsigned addr,
                                        input int unsigned dir_ofs);
      if (addr < dir_ofs)       return RGN_DATA;
      else if (addr == dir_ofs) return RGN_DIR;
      else                      return RGN_NONE;
   endfunction

endpackage

// File: rtl/maskgpio_sync.sv
module maskgpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_depth
      $error("maskgpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/maskgpio_decode.sv
module maskgpio_decode
   import maskgpio_pkg::*;
#(
   parameter int LINES      = 8,
   parameter int ADDR_W     = 11,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              data_wr,
   output logic              data_rd,
   output logic              dir_wr,
   output logic              dir_rd,
   output logic [LINES-1:0]  line_mask
);

   localparam int MASK_LSB = 2;
   localparam int MASK_MSB = MASK_LSB + LINES - 1;

   region_e rgn;

   always_comb begin
      rgn       = classify(int'(bus_addr), DIR_OFFSET);
      line_mask = bus_addr[MASK_MSB:MASK_LSB];
      data_wr   = bus_valid &&  bus_write && (rgn == RGN_DATA);
      data_rd   = bus_valid && !bus_write && (rgn == RGN_DATA);
      dir_wr    = bus_valid &&  bus_write && (rgn == RGN_DIR);
      dir_rd    = bus_valid && !bus_write && (rgn == RGN_DIR);
   end

endmodule

// File: rtl/maskgpio_store.sv
module maskgpio_store #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr,
   input  logic             dir_wr,
   input  logic [LINES-1:0] line_mask,
   input  logic [LINES-1:0] wdata,
   output logic [LINES-1:0] dir_q,
   output logic [LINES-1:0] out_q
);

   for (genvar n = 0; n < LINES; n++) begin : g_line
      // Direction bit: plain register
      always_ff @(posedge clk) begin
         if (!rst_n)      dir_q[n] <= 1'b0;
         else if (dir_wr) dir_q[n] <= wdata[n];
      end

      // Output bit: updated only when selected and already an output
      always_ff @(posedge clk) begin
         if (!rst_n)
            out_q[n] <= 1'b0;
         else if (data_wr && line_mask[n] && dir_q[n])
            out_q[n] <= wdata[n];
      end
   end

endmodule

// File: rtl/maskgpio_port.sv
module maskgpio_port #(
   parameter int LINES       = 8,
   parameter int ADDR_W      = 11,
   parameter int DIR_OFFSET  = 'h400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [LINES-1:0]  bus_wdata,
   output logic [LINES-1:0]  bus_rdata,
   input  logic [LINES-1:0]  pad_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe
);

   localparam int MASK_TOP = LINES + 2;

   if (LINES < 1 || LINES > 8) begin : g_bad_lines
      $error("maskgpio_port: LINES must be 1..8 for a byte bus");
   end
   if ((1 << MASK_TOP) > DIR_OFFSET) begin : g_bad_window
      $error("maskgpio_port: mask bits overlap the direction offset");
   end
   if ((1 << ADDR_W) <= DIR_OFFSET) begin : g_bad_addr
      $error("maskgpio_port: ADDR_W cannot reach the direction offset");
   end

   logic             data_wr, data_rd, dir_wr, dir_rd;
   logic [LINES-1:0] line_mask;
   logic [LINES-1:0] dir_q, out_q, pad_sync;
   logic [LINES-1:0] line_val;

   maskgpio_decode #(
      .LINES      (LINES),
      .ADDR_W     (ADDR_W),
      .DIR_OFFSET (DIR_OFFSET)
   ) u_decode (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .data_wr   (data_wr),
      .data_rd   (data_rd),
      .dir_wr    (dir_wr),
      .dir_rd    (dir_rd),
      .line_mask (line_mask)
   );

   maskgpio_store #(
      .LINES (LINES)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_wr   (data_wr),
      .dir_wr    (dir_wr),
      .line_mask (line_mask),
      .wdata     (bus_wdata),
      .dir_q     (dir_q),
      .out_q     (out_q)
   );

   maskgpio_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pad_sync)
   );

   // Per-line read source: driven value for outputs, pad for inputs
   for (genvar n = 0; n < LINES; n++) begin : g_rd
      assign line_val[n] = dir_q[n] ? out_q[n] : pad_sync[n];
   end

   always_comb begin
      if (data_rd)     bus_rdata = line_val & line_mask;
      else if (dir_rd) bus_rdata = dir_q;
      else             bus_rdata = '0;
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q;

endmodule

// File: rtl/maskgpio_checker.sv
module maskgpio_checker #(
   parameter int LINES      = 8,
   parameter int ADDR_W     = 11,
   parameter int DIR_OFFSET = 'h400
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [LINES-1:0]  bus_wdata,
   input logic [LINES-1:0]  bus_rdata,
   input logic [LINES-1:0]  pad_out,
   input logic [LINES-1:0]  pad_oe
);

   logic             in_window, at_dir;
   logic [LINES-1:0] amask;

   assign in_window = int'(bus_addr) < DIR_OFFSET;
   assign at_dir    = int'(bus_addr) == DIR_OFFSET;
   assign amask     = bus_addr[LINES+1:2];

   // R2
   a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && at_dir) |=> (pad_oe == $past(bus_wdata)));

   // R3
   a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && in_window)
      |=> ((pad_out & ~$past(amask)) == ($past(pad_out) & ~$past(amask))));

   // R4
   a_r4_input_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && in_window)
      |=> ((pad_out & ~$past(pad_oe)) == ($past(pad_out) & ~$past(pad_oe))));

   // R5
   a_r5_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && in_window) |-> ((bus_rdata & ~amask) == '0));

   // R8
   a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && !in_window && !at_dir) |-> (bus_rdata == '0));

   a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && !in_window && !at_dir)
      |=> ($stable(pad_out) && $stable(pad_oe)));

   // R10
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind maskgpio_port maskgpio_checker #(
   .LINES      (LINES),
   .ADDR_W     (ADDR_W),
   .DIR_OFFSET (DIR_OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/maskgpio_port_test.sv
module maskgpio_port_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 13;

   // Vector: {write, addr[10:0], data}; data is wdata for writes, expected rdata for reads
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b1, 11'h400, 8'h0F},  // R2 lines 0..3 outputs
      {1'b0, 11'h400, 8'h0F},  // R2 read back
      {1'b1, 11'h3FC, 8'hFF},  // R3 all masked; upper inputs dropped
      {1'b0, 11'h3FC, 8'hAF},  // R6 outputs F, pads upper A
      {1'b1, 11'h014, 8'h00},  // R3 mask lines 0,2
      {1'b0, 11'h03C, 8'h0A},  // R3 lines 1,3 kept
      {1'b0, 11'h028, 8'h0A},  // R5 mask lines 1,3
      {1'b0, 11'h3C0, 8'hA0},  // R6 input lines show pad
      {1'b0, 11'h000, 8'h00},  // R5 empty mask
      {1'b1, 11'h404, 8'hFF},  // R8 unmapped write
      {1'b0, 11'h400, 8'h0F},  // R8 direction unchanged
      {1'b0, 11'h404, 8'h00},  // R8 unmapped read
      {1'b1, 11'h3FC, 8'h55}   // R9 new low nibble
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [10:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pad_in = 8'hA5;
   logic [7:0]  pad_out, pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   maskgpio_port uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 pad_out", pad_out, 8'h00);
      bus_rd(11'h400, rd);
      check("R1 dir read", rd, 8'h00);

      // Table walk
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][19]) bus_wr(VEC[i][18:8], VEC[i][7:0]);
         else begin
            bus_rd(VEC[i][18:8], rd);
            check($sformatf("R2/R3/R5/R6/R8 vec %0d", i), rd, VEC[i][7:0]);
         end
      end
      @(negedge clk);
      check("R9 pad_out", pad_out, 8'h05);
      check("R2 pad_oe", pad_oe, 8'h0F);

      // R4: earlier 0xFF writes to lines 4..7 were dropped
      bus_wr(11'h400, 8'hFF);
      check("R4 after switch", pad_out, 8'h05);
      bus_wr(11'h3C0, 8'hF0);
      check("R4 preset after switch", pad_out, 8'hF5);

      // R10: write strobe without valid
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 11'h3FC; bus_wdata = 8'h00;
      @(posedge clk);
      @(negedge clk);
      bus_write = 1'b0;
      check("R10 pad_out", pad_out, 8'hF5);

      // R7: synchronizer depth
      bus_wr(11'h400, 8'h00);
      @(negedge clk) pad_in = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk) pad_in = 8'hFF;
      bus_rd(11'h3FC, rd);
      check("R7 after one edge", rd, 8'h00);
      bus_rd(11'h3FC, rd);
      check("R7 after two edges", rd, 8'hFF);

      // R6: mixed directions with new pad value
      bus_wr(11'h400, 8'hF0);
      bus_rd(11'h3FC, rd);
      check("R6 mixed", rd, 8'hFF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule